// File: doc/BRIEF.md
# Flow-Controlled Fill Data Receiver

This block collects one cache-line fill from a system bus as eight 64-bit quadwords. A fill command pulse opens the transfer and latches the miss tag. A data-valid strobe says which cycles carry a beat. Deasserting it between two-beat groups inserts bubble cycles of any length. Data reaches the block a fixed time after the strobe, so the strobe first passes through a delay pipeline of zero to three cycles, chosen by a 2-bit setting. Each captured beat then lines up with its data.

A fill-valid strobe is read only on the cycle that captures the second beat. If it is asserted there, the fill is committed. If it is deasserted, the fill is cancelled. A cancelled fill still takes in all eight beats before another command is accepted, and it reports its tag as still pending so that a later fill can refill the same entry. On completion the block presents the assembled line and raises a one-cycle done pulse carrying the tag and the cancel flag. All strobes are active-low at the pins.

Top module: `fill_rx`

## Requirements
- R1: A beat is qualified by the data-valid pin value sampled `dly_sel` cycles earlier (0 to 3). With `dly_sel` = 0 the same-cycle value qualifies.
- R2: While a fill is open, a beat is captured only in a cycle whose delayed data-valid is asserted. Bubbles of any length capture nothing.
- R3: The eighth captured beat completes the fill. In the next cycle `done` is high for exactly one cycle and `done_tag` equals the tag latched with the accepted command.
- R4: `line_out` holds beat k in bits [64k+63:64k], so beat 0 sits in the lowest quadword. It changes only together with `done`.
- R5: `done_cancel` is 1 exactly when the fill-valid pin was high (deasserted) in the cycle that captured beat 1. Its value in every other cycle has no effect.
- R6: A cancelled fill still needs all eight beats before it completes, and it accepts no new command in the meantime.
- R7: A fill command (low on `fill_cmd_n`) that arrives while a fill is open raises `proto_err` in the next cycle for one cycle. The command and its tag are ignored.
- R8: With data-valid and fill-valid tied asserted and `dly_sel` = 0, every fill takes eight back-to-back cycles and is committed. A new command may be accepted in the same cycle as the previous `done`.
- R9: After reset `done`, `done_cancel` and `proto_err` are 0 and `line_out` is zero. Data-valid asserted while no fill is open captures nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fill_cmd_n | input | 1 | Fill command pulse, active low |
| data_valid_n | input | 1 | Data-valid strobe, active low, before the delay pipeline |
| fill_valid_n | input | 1 | Fill-valid strobe, active low, read on the beat-1 capture |
| data_in | input | 64 | Quadword data bus |
| tag_in | input | 4 | Miss tag, latched with the accepted command |
| dly_sel | input | 2 | Number of cycles the data-valid strobe is delayed |
| line_out | output | 512 | Assembled line, beat 0 in the low quadword |
| done | output | 1 | One-cycle completion pulse |
| done_tag | output | 4 | Tag of the completed fill |
| done_cancel | output | 1 | 1 means the fill was cancelled and its tag stays pending |
| proto_err | output | 1 | A command arrived during an open fill |

## Verification
A delay pipeline tapped at the wrong depth would place quadwords from the wrong cycles into `line_out`. This shows up on the very next `done`, as a line mismatch or as a done pulse arriving a cycle early or late. A beat counter that slips would move the done pulse and shift later quadwords. A fill-valid flag sampled on the wrong beat would flip `done_cancel`, because the bench drives the opposite value on every other beat. A busy flag that clears too early would show as a missing `proto_err` pulse or as a foreign tag on the next `done`.

// File: rtl/fill_rx.sv
module fill_rx #(
  parameter int DW    = 64,
  parameter int BEATS = 8,
  parameter int TAGW  = 4,
  parameter int DLYW  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fill_cmd_n,
  input  logic                data_valid_n,
  input  logic                fill_valid_n,
  input  logic [DW-1:0]       data_in,
  input  logic [TAGW-1:0]     tag_in,
  input  logic [DLYW-1:0]     dly_sel,
  output logic [BEATS*DW-1:0] line_out,
  output logic                done,
  output logic [TAGW-1:0]     done_tag,
  output logic                done_cancel,
  output logic                proto_err
);
  localparam int MAXD = (1 << DLYW) - 1;
  localparam int CW   = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [MAXD-1:0] dv_sr;
  logic [MAXD:0]   taps;
  logic            dv_d, cmd, busy, start, cap, last, cancel_q, cancel_now;
  logic [CW-1:0]   cnt;
  logic [TAGW-1:0] tag_q;
  logic [DW-1:0]   asm_q  [BEATS];
  logic [DW-1:0]   line_q [BEATS];

  assign cmd   = ~fill_cmd_n;
  assign taps  = {dv_sr, ~data_valid_n};
  assign dv_d  = taps[dly_sel];
  assign start = cmd & ~busy;
  assign cap   = dv_d & (busy | start);
  assign last  = cap & (cnt == CW'(BEATS - 1));
  assign cancel_now = (cnt == CW'(1)) ? fill_valid_n : cancel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dv_sr <= '0;
    else        dv_sr <= taps[MAXD-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      cnt         <= '0;
      tag_q       <= '0;
      cancel_q    <= 1'b0;
      done        <= 1'b0;
      done_tag    <= '0;
      done_cancel <= 1'b0;
      proto_err   <= 1'b0;
    end else begin
      proto_err <= cmd & busy;
      done      <= last;
      if (last)       busy <= 1'b0;
      else if (start) busy <= 1'b1;
      if (start) begin
        tag_q    <= tag_in;
        cancel_q <= 1'b0;
      end
      if (cap) begin
        cnt <= last ? '0 : cnt + CW'(1);
        if (cnt == CW'(1)) cancel_q <= fill_valid_n;
      end
      if (last) begin
        done_tag    <= tag_q;
        done_cancel <= cancel_now;
      end else begin
        done_cancel <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < BEATS; g++) begin : g_beat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        asm_q[g]  <= '0;
        line_q[g] <= '0;
      end else begin
        if (cap && cnt == CW'(g)) asm_q[g] <= data_in;
        if (last) line_q[g] <= (g == BEATS - 1) ? data_in : asm_q[g];
      end
    end
    assign line_out[g*DW +: DW] = line_q[g];
  end
endmodule

module fill_rx_chk #(
  parameter int DW    = 64,
  parameter int BEATS = 8,
  parameter int TAGW  = 4
) (
  input logic                clk,
  input logic                rst_n,
  input logic                fill_cmd_n,
  input logic [BEATS*DW-1:0] line_out,
  input logic                done,
  input logic [TAGW-1:0]     done_tag,
  input logic                done_cancel,
  input logic                proto_err
);
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |-> $past(!fill_cmd_n));
  assert_cancel_with_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done_cancel |-> done);
  assert_line_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(line_out) && $stable(done_tag)));
endmodule

bind fill_rx fill_rx_chk #(.DW(DW), .BEATS(BEATS), .TAGW(TAGW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fill_cmd_n(fill_cmd_n), .line_out(line_out),
  .done(done), .done_tag(done_tag), .done_cancel(done_cancel),
  .proto_err(proto_err));

// File: tb/sim_fill_rx.sv
module sim_fill_rx;
  logic         clk = 1'b0, rst_n = 1'b0;
  logic         cmd_n = 1'b1, dv_n = 1'b1, fv_n = 1'b1;
  logic [63:0]  din = '0;
  logic [3:0]   tag = '0;
  logic [1:0]   dly = '0;
  logic [511:0] line_out;
  logic         done, done_cancel, proto_err;
  logic [3:0]   done_tag;

  int checks = 0, errors = 0, cyc = 0;
  logic [511:0] q_line[$];
  logic [3:0]   q_tag[$];
  bit           q_can[$];
  int           q_cyc[$];

  fill_rx u0 (.clk(clk), .rst_n(rst_n), .fill_cmd_n(cmd_n), .data_valid_n(dv_n),
    .fill_valid_n(fv_n), .data_in(din), .tag_in(tag), .dly_sel(dly),
    .line_out(line_out), .done(done), .done_tag(done_tag),
    .done_cancel(done_cancel), .proto_err(proto_err));

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (q_line.size() == 0) begin
        chk(0, "R3", "unexpected done", 1, 0);
      end else begin
        logic [511:0] el; logic [3:0] et; bit ec; int ecy;
        el = q_line.pop_front(); et = q_tag.pop_front();
        ec = q_can.pop_front();  ecy = q_cyc.pop_front();
        chk(cyc == ecy, "R3", "done cycle", 512'(cyc), 512'(ecy));
        chk(line_out == el, "R4", "line", line_out, el);
        chk(done_tag == et, "R3", "tag", 512'(done_tag), 512'(et));
        chk(done_cancel == ec, "R5", "cancel", 512'(done_cancel), 512'(ec));
      end
    end
  end

  task automatic idle(input int n, input bit dv_noise);
    bit saw = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (done) saw = 1;
      cmd_n = 1'b1; dv_n = dv_noise ? i[0] : 1'b1; fv_n = i[1];
      din = {32'hBAD0BAD0, 32'(i)}; tag = 4'(i);
    end
    if (dv_noise) chk(!saw, "R9", "done while idle", 512'(saw), 0);
  endtask

  task automatic do_fill(input logic [3:0] t, input int d, input logic [31:0] pat,
                         input bit can, input int err_cyc, input bit tie);
    logic [511:0] exp = '0;
    int nc = 0, i = 0;
    bit cap;
    dly = 2'(d);
    while (nc < 8) begin
      @(negedge clk);
      if (err_cyc >= 0 && i == err_cyc + 1)
        chk(proto_err == 1'b1, "R7", "proto_err", 512'(proto_err), 1);
      cmd_n = !(i == 0 || i == err_cyc);
      tag   = (i == 0) ? t : ~t;
      dv_n  = tie ? 1'b0 : !(i < 32 && pat[i]);
      cap   = (i >= d) ? pat[i-d] : 1'b0;
      if (cap) begin
        din = {4'hA, t, 8'(nc), 16'(cyc), 32'h5EED0000 ^ 32'(i)};
        exp[nc*64 +: 64] = din;
        fv_n = tie ? 1'b0 : ((nc == 1) ? can : !can);
        nc++;
      end else begin
        din = {32'hBAD0BAD0, 32'(i)};
        fv_n = i[0];
      end
      i++;
    end
    q_line.push_back(exp); q_tag.push_back(t);
    q_can.push_back(can);  q_cyc.push_back(cyc + 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(done == 0 && proto_err == 0 && done_cancel == 0, "R9", "reset flags",
        512'({done, proto_err, done_cancel}), 0);
    chk(line_out == '0, "R9", "reset line", line_out, 0);

    // R8: tied strobes, back-to-back fills
    do_fill(4'h1, 0, 32'hFF, 0, -1, 1);
    do_fill(4'h2, 0, 32'hFF, 0, -1, 1);
    do_fill(4'h3, 0, 32'hFF, 0, -1, 1);
    idle(4, 0);
    // R1 R2: delay 1 with bubbles
    do_fill(4'h4, 1, 32'h30C33, 0, -1, 0);
    idle(4, 0);
    // R5 R6 R7: delay 3, cancelled, command mid-fill
    do_fill(4'h5, 3, 32'h0F0F, 1, 5, 0);
    idle(4, 0);
    // R7: delay 2, committed, command mid-fill
    do_fill(4'h6, 2, 32'hFF, 0, 3, 0);
    idle(4, 0);
    // R9: data-valid while idle, then R1 fill
    dly = 2'd2;
    idle(6, 1);
    idle(5, 0);
    do_fill(4'h7, 2, 32'h33033, 0, -1, 0);
    idle(4, 0);
    // R5 R6: cancelled with long bubbles, delay 0
    do_fill(4'h8, 0, 32'hC0C0C3, 1, 9, 0);
    idle(4, 0);
    do_fill(4'h9, 3, 32'h3333, 0, -1, 0);
    idle(6, 0);

    chk(q_line.size() == 0, "R3", "missing done", 512'(q_line.size()), 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R3 watchdog actual %0d expected 0", cyc);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule